// File: doc/BRIEF.md
# Statically Scheduled Crossbar Switch

This block is the switch inside one tile of a mesh. It joins four neighbour links (north, east, south, west) and the local processor port through a five-by-five crossbar. Words carry no header. Each cycle the crossbar is set by one route word taken from a small route program that software writes in advance through a configuration write port. A program counter steps through the program and jumps back to entry 0 after a word marked as last. Because the program can name a different set of connections on every step, the connection pattern can change every cycle.

All links use valid/ready handshakes. Every input has a short buffer. A route word takes effect as one unit: it advances only in the cycle when every transfer it names can complete. If any named source is empty or any named destination is not ready, the whole word waits. One input may feed several outputs in the same word, and it is consumed once, when the word fires. Schedules are compiled elsewhere. This block only carries them out.

Top module: `static_xbar_switch`

## Requirements
- R1: After reset every out_valid_o bit is low, every in_ready_o bit is high, the program counter is at entry 0, and every route entry reads as "all outputs unconnected" with the last flag set.
- R2: A route word is 16 bits. Bits [3o+2:3o] choose the source for output o, and bit 15 is the last flag. Port index order for lanes, fields and sources is N=0, E=1, S=2, W=3, processor=4. A field value of 0 to 4 names that input. Values 5, 6 and 7 leave the output unconnected.
- R3: Words reach each output in the order they arrived on the chosen input, with their value unchanged.
- R4: A connected output shows valid only when every source named in the current word holds data and every other connected output of the word is ready. An unconnected output never shows valid. In any cycle, either all connected outputs complete a handshake or none does.
- R5: An input that feeds several outputs in one word is removed from its buffer exactly once, in the cycle the word fires.
- R6: Each fired word moves the program counter on by one. After a word with the last flag, or after entry ROUTE_DEPTH-1, it returns to 0. A stalled word holds the counter.
- R7: A word that connects no output fires in one cycle with no transfer.
- R8: Each input buffers BUF_DEPTH (2) words. in_ready_o drops while that buffer is full.
- R9: While run_i is low, no output shows valid, no buffered input is consumed, and the program counter holds.
- R10: With cfg_we_i high at a clock edge, cfg_word_i is written into entry cfg_addr_i. It governs routing from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Enables execution of the route program |
| cfg_we_i | input | 1 | Route entry write strobe |
| cfg_addr_i | input | AW | Route entry index |
| cfg_word_i | input | 16 | Route word to write |
| in_valid_i | input | 5 | Per-input valid, lane order N,E,S,W,P |
| in_ready_o | output | 5 | Per-input ready (buffer not full) |
| in_data_i | input | 5*DATA_W | Input data, lane p at [p*DATA_W +: DATA_W] |
| out_valid_o | output | 5 | Per-output valid |
| out_ready_i | input | 5 | Per-output ready from the neighbour |
| out_data_o | output | 5*DATA_W | Output data, lane o at [o*DATA_W +: DATA_W] |

## Verification
The assertions assume that neighbours obey the handshake: a ready input may be dropped at any time, and an input's valid and data are meaningful only when both valid and ready are high. The assertions also assume that the route memory is rewritten only while run_i is low or while the entry being written is idle. The stimulus reloads programs only with run_i low and, where needed, after a reset, so the program counter always starts from entry 0. The stimulus changes ready only between clock edges and never relies on an input word being taken without a handshake.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
  localparam int unsigned NPORT  = 5;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned WORD_W = NPORT * SEL_W + 1;

  typedef enum logic [SEL_W-1:0] {
    PORT_N    = 3'd0,
    PORT_E    = 3'd1,
    PORT_S    = 3'd2,
    PORT_W    = 3'd3,
    PORT_PROC = 3'd4,
    PORT_NONE = 3'd7
  } port_e;
endpackage

// File: rtl/sxb_in_fifo.sv
module sxb_in_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/sxb_route_seq.sv
module sxb_route_seq #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  input  logic              advance_i,
  output logic [WORD_W-1:0] word_o,
  output logic [AW-1:0]     pc_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     pc_q;

  // reset value: every field unconnected, last flag set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '1;
    end else if (cfg_we_i) begin
      mem_q[cfg_addr_i] <= cfg_word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (advance_i) begin
      if (word_o[WORD_W-1] || pc_q == AW'(DEPTH - 1)) pc_q <= '0;
      else                                            pc_q <= pc_q + AW'(1);
    end
  end

  assign word_o = mem_q[pc_q];
  assign pc_o   = pc_q;
endmodule

// File: rtl/sxb_fire_ctrl.sv
module sxb_fire_ctrl #(
  parameter int unsigned NP = 5,
  parameter int unsigned SW = 3
) (
  input  logic [NP*SW-1:0] sel_i,
  input  logic [NP-1:0]    avail_i,
  input  logic [NP-1:0]    out_ready_i,
  input  logic             run_i,
  output logic [NP-1:0]    named_o,
  output logic [NP-1:0]    out_valid_o,
  output logic [NP-1:0]    pop_o,
  output logic             fire_o
);
  logic [NP-1:0] used;
  logic [NP-1:0] blocked;
  logic          src_ok;

  always_comb begin
    named_o = '0;
    used    = '0;
    src_ok  = 1'b1;
    for (int o = 0; o < int'(NP); o++) begin
      logic [SW-1:0] s;
      s = sel_i[o*SW +: SW];
      if (s < SW'(NP)) begin
        named_o[o] = 1'b1;
        used[s]    = 1'b1;
        if (!avail_i[s]) src_ok = 1'b0;
      end
    end
    blocked = named_o & ~out_ready_i;
    // valid of an output never looks at its own ready
    for (int o = 0; o < int'(NP); o++) begin
      out_valid_o[o] = run_i && src_ok && named_o[o]
                       && ((blocked & ~(NP'(1) << o)) == '0);
    end
    fire_o = run_i && src_ok && (blocked == '0);
    pop_o  = fire_o ? used : '0;
  end
endmodule

// File: rtl/static_xbar_switch.sv
module static_xbar_switch #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ROUTE_DEPTH = 16,
  parameter int unsigned BUF_DEPTH   = 2,
  localparam int unsigned NP         = sxb_pkg::NPORT,
  localparam int unsigned SW         = sxb_pkg::SEL_W,
  localparam int unsigned WORD_W     = sxb_pkg::WORD_W,
  localparam int unsigned AW         = $clog2(ROUTE_DEPTH),
  localparam int unsigned CW         = $clog2(BUF_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic                 cfg_we_i,
  input  logic [AW-1:0]        cfg_addr_i,
  input  logic [WORD_W-1:0]    cfg_word_i,
  input  logic [NP-1:0]        in_valid_i,
  output logic [NP-1:0]        in_ready_o,
  input  logic [NP*DATA_W-1:0] in_data_i,
  output logic [NP-1:0]        out_valid_o,
  input  logic [NP-1:0]        out_ready_i,
  output logic [NP*DATA_W-1:0] out_data_o
);
  logic [WORD_W-1:0] route_word;
  logic [AW-1:0]     pc;
  logic [NP-1:0]     named, pop, full, empty;
  logic              fire;
  logic [DATA_W-1:0] head [NP];
  logic [CW-1:0]     fill [NP];

  sxb_route_seq #(.DEPTH(ROUTE_DEPTH), .WORD_W(WORD_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_word_i (cfg_word_i),
    .advance_i  (fire),
    .word_o     (route_word),
    .pc_o       (pc)
  );

  for (genvar p = 0; p < NP; p++) begin : g_in
    sxb_in_fifo #(.DW(DATA_W), .DEPTH(BUF_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[p] && !full[p]),
      .data_i  (in_data_i[p*DATA_W +: DATA_W]),
      .pop_i   (pop[p]),
      .full_o  (full[p]),
      .empty_o (empty[p]),
      .head_o  (head[p]),
      .count_o (fill[p])
    );
  end

  assign in_ready_o = ~full;

  sxb_fire_ctrl #(.NP(NP), .SW(SW)) u_ctrl (
    .sel_i       (route_word[NP*SW-1:0]),
    .avail_i     (~empty),
    .out_ready_i (out_ready_i),
    .run_i       (run_i),
    .named_o     (named),
    .out_valid_o (out_valid_o),
    .pop_o       (pop),
    .fire_o      (fire)
  );

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [SW-1:0] s;
    assign s = route_word[o*SW +: SW];
    assign out_data_o[o*DATA_W +: DATA_W] = (s < SW'(NP)) ? head[s] : '0;
  end
endmodule

// File: rtl/sxb_checker.sv
module sxb_checker #(
  parameter int unsigned ROUTE_DEPTH = 16,
  parameter int unsigned NP          = 5,
  localparam int unsigned AW         = $clog2(ROUTE_DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic [NP-1:0] out_valid_i,
  input logic [NP-1:0] out_ready_i,
  input logic [NP-1:0] named_i,
  input logic [NP-1:0] pop_i,
  input logic          fire_i,
  input logic          last_i,
  input logic [AW-1:0] pc_i
);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> out_valid_i == '0);

  a_r4_unnamed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i & ~named_i) == '0);

  a_r4_all_or_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_valid_i & out_ready_i) == '0) || ((out_valid_i & out_ready_i) == named_i));

  a_r5_pop_on_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i != '0) |-> fire_i);

  a_r6_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(pc_i));

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && last_i) |=> pc_i == '0);

  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !last_i && pc_i != AW'(ROUTE_DEPTH - 1)) |=> pc_i == $past(pc_i) + AW'(1));
endmodule

bind static_xbar_switch sxb_checker #(.ROUTE_DEPTH(ROUTE_DEPTH), .NP(NP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .named_i     (named),
  .pop_i       (pop),
  .fire_i      (fire),
  .last_i      (route_word[WORD_W-1]),
  .pc_i        (pc)
);

// File: tb/static_xbar_switch_test.sv
module static_xbar_switch_test;
  localparam int DW = 32;
  localparam int NP = 5;
  localparam int N = 0, E = 1, S = 2, W = 3, P = 4, X = 7;

  logic          clk = 0, rst_n = 0, run = 0, cfg_we = 0;
  logic [3:0]    cfg_addr = '0;
  logic [15:0]   cfg_word = '0;
  logic [NP-1:0] in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [DW-1:0] in_data [NP];
  logic [NP*DW-1:0] in_flat, out_flat;
  logic [DW-1:0] exp_q [NP][$];
  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  for (genvar p = 0; p < NP; p++) begin : g_pack
    assign in_flat[p*DW +: DW] = in_data[p];
  end

  static_xbar_switch uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_word_i(cfg_word),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_flat),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_flat)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare every completed output transfer against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          if (exp_q[o].size() == 0) begin
            chk(0, cur_req, out_flat[o*DW +: DW], 64'hDEAD);
          end else begin
            logic [DW-1:0] e;
            e = exp_q[o].pop_front();
            chk(out_flat[o*DW +: DW] == e, cur_req, out_flat[o*DW +: DW], e);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] rw(int fn, int fe, int fs, int fw, int fp, bit last);
    return {last, 3'(fp), 3'(fw), 3'(fs), 3'(fe), 3'(fn)};
  endfunction

  task automatic cfg(input int a, input logic [15:0] w);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = 4'(a); cfg_word = w;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send(input int p, input logic [DW-1:0] d);
    @(posedge clk); #1;
    in_valid[p] = 1; in_data[p] = d;
    do @(negedge clk); while (!in_ready[p]);
    @(posedge clk); #1;
    in_valid[p] = 0;
  endtask

  task automatic expect_out(input int o, input logic [DW-1:0] d);
    exp_q[o].push_back(d);
  endtask

  task automatic drain(input string req);
    int t = 0;
    while ((exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size()
            + exp_q[4].size()) != 0 && t < 2000) begin
      @(negedge clk); t++;
    end
    repeat (4) @(negedge clk);
    for (int o = 0; o < NP; o++) chk(exp_q[o].size() == 0, req, exp_q[o].size(), 0);
  endtask

  task automatic do_reset();
    run = 0;
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) in_data[p] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    @(negedge clk);
    chk(out_valid == '0, "R1", out_valid, 0);
    chk(in_ready == 5'h1F, "R1", in_ready, 5'h1F);
    // R1: default entries connect nothing
    run = 1;
    send(N, 32'hA0A0_0001);
    repeat (5) @(negedge clk);
    chk(out_valid == '0, "R1", out_valid, 0);
    // R10: write entry 0 = E<-N, last; buffered word now flows out on E
    cur_req = "R10";
    run = 0;
    cfg(0, rw(X, N, X, X, X, 1));
    expect_out(E, 32'hA0A0_0001);
    run = 1;
    drain("R10");

    // R3: stream with back-pressure on E
    cur_req = "R3";
    for (int i = 0; i < 8; i++) expect_out(E, 32'h3300 + i);
    fork
      for (int i = 0; i < 8; i++) send(N, 32'h3300 + i);
      for (int k = 0; k < 30; k++) begin
        @(posedge clk); #1 out_ready[E] = (k % 3) != 1;
      end
    join
    #1 out_ready = '1;
    drain("R3");

    // R4/R5: fan-out W->E and W->P, plus N->S; P held not ready
    do_reset();
    cur_req = "R4";
    cfg(0, rw(X, W, N, X, W, 1));
    out_ready[P] = 0;
    run = 1;
    fork
      send(W, 32'h5555_0001);
      send(N, 32'h4444_0001);
    join
    repeat (3) @(negedge clk);
    chk(out_valid == 5'b10000, "R4", out_valid, 5'b10000);
    chk(in_ready[W] == 1'b1, "R5", in_ready[W], 1);
    cur_req = "R5";
    expect_out(E, 32'h5555_0001);
    expect_out(P, 32'h5555_0001);
    expect_out(S, 32'h4444_0001);
    @(posedge clk); #1 out_ready[P] = 1;
    drain("R5");
    chk(out_valid == '0, "R5", out_valid, 0);

    // R6: three-word loop E<-N, W<-S, P<-N
    do_reset();
    cur_req = "R6";
    cfg(0, rw(X, N, X, X, X, 0));
    cfg(1, rw(X, X, X, S, X, 0));
    cfg(2, rw(X, X, X, X, N, 1));
    run = 1;
    for (int r = 0; r < 3; r++) begin
      expect_out(E, 32'h6000 + 2*r);
      expect_out(P, 32'h6001 + 2*r);
      expect_out(W, 32'h7000 + r);
    end
    fork
      for (int i = 0; i < 6; i++) send(N, 32'h6000 + i);
      for (int i = 0; i < 3; i++) send(S, 32'h7000 + i);
    join
    drain("R6");

    // R6: wrap after the final entry with no last flag
    do_reset();
    for (int a = 0; a < 16; a++)
      cfg(a, (a == 15) ? rw(X, X, X, N, X, 0) : rw(X, N, X, X, X, 0));
    run = 1;
    for (int i = 0; i < 20; i++) expect_out((i == 15) ? W : E, 32'h8000 + i);
    for (int i = 0; i < 20; i++) send(N, 32'h8000 + i);
    drain("R6");

    // R7/R2: empty word, then word with codes 5 and 6 as unconnected
    do_reset();
    cur_req = "R7";
    cfg(0, rw(X, X, X, X, X, 0));
    cfg(1, rw(5, 6, N, X, X, 1));
    run = 1;
    for (int i = 0; i < 4; i++) expect_out(S, 32'h9000 + i);
    for (int i = 0; i < 4; i++) send(N, 32'h9000 + i);
    drain("R7");
    chk(out_valid[E] == 1'b0 && out_valid[N] == 1'b0, "R2", out_valid, 0);

    // R8/R9: run low fills the N buffer, nothing leaves
    do_reset();
    cur_req = "R9";
    cfg(0, rw(X, N, X, X, X, 1));
    for (int i = 0; i < 3; i++) expect_out(E, 32'hB000 + i);
    fork
      for (int i = 0; i < 3; i++) send(N, 32'hB000 + i);
      begin
        repeat (8) @(negedge clk);
        chk(in_ready[N] == 1'b0, "R8", in_ready[N], 0);
        chk(out_valid == '0, "R9", out_valid, 0);
        @(posedge clk); #1 run = 1;
      end
    join
    drain("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule